// File: doc/BRIEF.md
# Low-Power Clock Source Controller

This block produces the core clock of a low-power subsystem. A high-frequency crystal clock or a frequency-locked-loop (FLL) output is chosen as the source and divided by 1, 2, 4 or 8. A separate low-power mode runs the core directly from the 32 kHz clock. That 32 kHz clock is never a normal source. It serves as the FLL reference and as the clock for the real-time-clock and display logic, whatever core source is in use. Each change of clock path goes through a glitch-free switch, and the divider changes its ratio only at a safe point.

Software controls the block through one 8-bit control register, written on `wr_en` in the high-frequency clock domain and read back on `rd_data`. The 32 kHz clock can come from the internal crystal oscillator or from an external input. It can be turned off completely, but only while an interlock permits this. A request to turn it off at any other time is ignored.

Top module: `lpclk_ctrl`

## Requirements
- R1: After reset `rd_data` reads 0x00. The core runs from the high-frequency clock at divide by 1, and the 32 kHz clock comes from the internal oscillator.
- R2: Register bits [1:0] set the divide ratio: code 0 gives /1, code 1 gives /2, code 2 gives /4 and code 3 gives /8. The core clock period is the source period times that ratio.
- R3: The core runs from the FLL clock only when bit 3 (FLL select) and bit 6 (FLL enable, driven out on `fll_en`) are both 1 and `fll_lock` is high. In every other case it runs from the high-frequency clock.
- R4: Bit 4 (low-power mode) set to 1 runs the core directly from the 32 kHz clock, with no division.
- R5: Bit 5 (bypass) set to 1 takes the 32 kHz clock from `clk32_ext`. Set to 0, it takes it from `clk32_xtal`.
- R6: `rtc_clk` and `fll_ref` carry the 32 kHz clock whatever core source is selected.
- R7: No high or low phase of `core_clk` is shorter than half the period of the fastest input clock. At any time at most one source of a switch drives its output.
- R8: A new divide ratio takes effect only when the divider count has returned to zero.
- R9: Writing 1 to bit 2 (32 kHz off) takes effect only if `rtc_busy` is low and low-power mode is neither requested nor active. If it is refused, bit 2 reads 0. Once it takes effect, `rtc_clk` and `fll_ref` stay low.
- R10: A write that sets bit 4 is ignored for that bit if the same write leaves the 32 kHz clock off. Bit 4 then reads 0 and the core keeps its divided source.
- R11: Bit 7 is not implemented and always reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_hf | input | 1 | High-frequency crystal clock; also the register clock |
| clk_fll | input | 1 | FLL output clock |
| clk32_xtal | input | 1 | 32 kHz clock from the internal oscillator |
| clk32_ext | input | 1 | 32 kHz clock from the external input |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read-back |
| fll_lock | input | 1 | FLL lock indication |
| rtc_busy | input | 1 | RTC or display is using the 32 kHz clock |
| fll_en | output | 1 | FLL enable |
| fll_ref | output | 1 | 32 kHz reference to the FLL |
| rtc_clk | output | 1 | 32 kHz clock to the RTC and display |
| core_clk | output | 1 | Core clock |

## Verification
The bench targets the interlock corners. One is a turn-off request while `rtc_busy` is high. Another is a request made while low-power mode is active. A third is a single write that asks for both turn-off and low-power mode. A faulty interlock would either stop `rtc_clk` under a live RTC or switch the core onto a dead clock and hang it. The bench also drops `fll_lock` while the FLL is selected. A design that ignored lock would keep the core on an unlocked FLL, and the measured period would show it. Throughout the run, a monitor measures every phase of `core_clk` across all source and ratio changes. A switch that lets both clocks through, or a divider that reloads mid-pulse, would produce a runt phase, and the monitor flags it.

// File: rtl/lpclk_pkg.sv
`timescale 1ns/1ps
package lpclk_pkg;
  localparam int DIV_W = 2;
  // packed so that field order equals read-back bit order (bit 6 down to 0)
  typedef struct packed {
    logic             fll_en;
    logic             byp;
    logic             lp;
    logic             fll_sel;
    logic             off;
    logic [DIV_W-1:0] div;
  } cfg_t;
  localparam int CFG_W = $bits(cfg_t);
endpackage

// File: rtl/lpclk_sync.sv
`timescale 1ns/1ps
module lpclk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/lpclk_regs.sv
`timescale 1ns/1ps
module lpclk_regs
  import lpclk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       rtc_busy,
  input  logic       lp_active,
  output cfg_t       cfg,
  output logic [7:0] rd_data
);
  cfg_t cfg_q, cfg_n;
  logic dis_ok;

  // turning the 32k clock off is safe only when nothing depends on it
  assign dis_ok = !rtc_busy && !cfg_q.lp && !lp_active;

  always_comb begin
    cfg_n = cfg_q;
    if (wr_en) begin
      cfg_n.div     = wr_data[DIV_W-1:0];
      cfg_n.fll_sel = wr_data[3];
      cfg_n.fll_en  = wr_data[6];
      cfg_n.byp     = wr_data[5];
      cfg_n.off     = wr_data[2] && (cfg_q.off || dis_ok);
      cfg_n.lp      = wr_data[4] && !cfg_n.off;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_n;
  end

  assign cfg     = cfg_q;
  assign rd_data = {{(8-CFG_W){1'b0}}, cfg_q};

  assert_dis_guard_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_q.off) |-> $past(!rtc_busy && !lp_active));

  assert_lp_needs_clk_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q.lp |-> !cfg_q.off);
endmodule

// File: rtl/lpclk_gfmux.sv
`timescale 1ns/1ps
module lpclk_gfmux #(
  parameter int STAGES = 2
) (
  input  logic clk_a,
  input  logic clk_b,
  input  logic rst_n,
  input  logic sel,
  output logic clk_out,
  output logic b_on
);
  logic [1:0] clks;
  logic [1:0] en;

  assign clks = {clk_b, clk_a};

  for (genvar i = 0; i < 2; i++) begin : g_side
    logic              want;
    logic [STAGES-2:0] pipe;
    logic              en_q;

    // a side may only start once the other side has released
    assign want = ((i == 1) ? sel : !sel) && !en[1-i];

    always_ff @(posedge clks[i] or negedge rst_n) begin
      if (!rst_n) pipe <= '0;
      else begin
        pipe[0] <= want;
        for (int k = 1; k < STAGES-1; k++) pipe[k] <= pipe[k-1];
      end
    end

    // enable changes only while this clock is low
    always_ff @(negedge clks[i] or negedge rst_n) begin
      if (!rst_n) en_q <= 1'b0;
      else        en_q <= pipe[STAGES-2];
    end

    assign en[i] = en_q;
  end

  assign clk_out = (clk_a && en[0]) || (clk_b && en[1]);
  assign b_on    = en[1];

  always_comb begin
    if (rst_n) begin
      assert_excl_R7: assert (!(en[0] && en[1]));
    end
  end
endmodule

// File: rtl/lpclk_div.sv
`timescale 1ns/1ps
module lpclk_div #(
  parameter int CODE_W = 2,
  parameter int STAGES = 2
) (
  input  logic              clk_in,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] code_in,
  output logic              clk_out
);
  localparam int CNT_W = (1 << CODE_W) - 1;

  logic [CODE_W-1:0] code_s1, code_s2;
  logic [CNT_W-1:0]  cnt_q, cnt_n, load_v;
  logic              gate_q;

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      code_s1 <= '0;
      code_s2 <= '0;
    end else begin
      code_s1 <= code_in;
      code_s2 <= code_s1;
    end
  end

  assign load_v = CNT_W'((1 << code_s2) - 1);

  // reload only at zero; a code still settling in the sync is not taken
  always_comb begin
    if (cnt_q != '0)             cnt_n = cnt_q - 1'b1;
    else if (code_s1 == code_s2) cnt_n = load_v;
    else                         cnt_n = '0;
  end

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  always_ff @(negedge clk_in or negedge rst_n) begin
    if (!rst_n) gate_q <= 1'b0;
    else        gate_q <= (cnt_q == '0);
  end

  assign clk_out = clk_in && gate_q;

  assert_ratio_at_zero_R8: assert property (@(posedge clk_in) disable iff (!rst_n)
    (cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/lpclk_ctrl.sv
`timescale 1ns/1ps
module lpclk_ctrl
  import lpclk_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_hf,
  input  logic       clk_fll,
  input  logic       clk32_xtal,
  input  logic       clk32_ext,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       fll_lock,
  input  logic       rtc_busy,
  output logic       fll_en,
  output logic       fll_ref,
  output logic       rtc_clk,
  output logic       core_clk
);
  cfg_t cfg;
  logic rst_s, lock_s, lp_on, lp_on_s;
  logic fll_use_q, fll_use_n;
  logic clk32, src_clk, div_clk;

  lpclk_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk_hf), .rst_n(rst_n), .d(1'b1), .q(rst_s));

  lpclk_sync #(.STAGES(SYNC_STAGES)) u_lock (
    .clk(clk_hf), .rst_n(rst_s), .d(fll_lock), .q(lock_s));

  lpclk_sync #(.STAGES(SYNC_STAGES)) u_lpsync (
    .clk(clk_hf), .rst_n(rst_s), .d(lp_on), .q(lp_on_s));

  lpclk_regs u_regs (
    .clk(clk_hf), .rst_n(rst_s), .wr_en(wr_en), .wr_data(wr_data),
    .rtc_busy(rtc_busy), .lp_active(lp_on_s), .cfg(cfg), .rd_data(rd_data));

  // FLL is used only while requested, enabled and locked
  assign fll_use_n = cfg.fll_sel && cfg.fll_en && lock_s;

  always_ff @(posedge clk_hf or negedge rst_s) begin
    if (!rst_s) fll_use_q <= 1'b0;
    else        fll_use_q <= fll_use_n;
  end

  assign clk32   = cfg.off ? 1'b0 : (cfg.byp ? clk32_ext : clk32_xtal);
  assign rtc_clk = clk32;
  assign fll_ref = clk32;
  assign fll_en  = cfg.fll_en;

  lpclk_gfmux #(.STAGES(SYNC_STAGES)) u_srcmux (
    .clk_a(clk_hf), .clk_b(clk_fll), .rst_n(rst_s), .sel(fll_use_q),
    .clk_out(src_clk), .b_on());

  lpclk_div #(.CODE_W(DIV_W), .STAGES(SYNC_STAGES)) u_div (
    .clk_in(src_clk), .rst_n(rst_s), .code_in(cfg.div), .clk_out(div_clk));

  lpclk_gfmux #(.STAGES(SYNC_STAGES)) u_lpmux (
    .clk_a(div_clk), .clk_b(clk32), .rst_n(rst_s), .sel(cfg.lp),
    .clk_out(core_clk), .b_on(lp_on));

  assert_fll_gate_R3: assert property (@(posedge clk_hf) disable iff (!rst_s)
    $rose(fll_use_q) |-> (fll_en && $past(fll_lock)));

  assert_ref_alive_R6: assert property (@(posedge clk_hf) disable iff (!rst_s)
    (rd_data[2] == 1'b0 && $past(rd_data[2]) == 1'b0 && !cfg.byp) |-> (rtc_clk == clk32_xtal));
endmodule

// File: tb/sim_lpclk_ctrl.sv
`timescale 1ns/1ps
module sim_lpclk_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int FLL_HALF   = 3;
  localparam int XT_HALF    = 150;
  localparam int EXT_HALF   = 110;
  localparam int SETTLE     = 3000;
  localparam int NVEC       = 11;
  // {write data, fll_lock, expected core period in ns}
  localparam logic [31:0] VEC [0:NVEC-1] = '{
    32'h00_00_000A, 32'h01_00_0014, 32'h02_00_0028, 32'h03_00_0050,
    32'h48_01_0006, 32'h49_01_000C, 32'h4B_01_0030, 32'h48_00_000A,
    32'h10_00_012C, 32'h30_00_00DC, 32'h00_00_000A};

  logic clk_hf = 0, clk_fll = 0, clk32_xtal = 0, clk32_ext = 0;
  logic rst_n, wr_en, fll_lock, rtc_busy;
  logic [7:0] wr_data, rd_data;
  logic fll_en, fll_ref, rtc_clk, core_clk;

  int total = 0, bad = 0, runts = 0, rtc_edges = 0, ref_edges = 0;
  bit mon_on = 0;
  realtime last_t = 0;

  always #(CLK_PERIOD/2) clk_hf = ~clk_hf;
  always #(FLL_HALF)     clk_fll = ~clk_fll;
  always #(XT_HALF)      clk32_xtal = ~clk32_xtal;
  always #(EXT_HALF)     clk32_ext = ~clk32_ext;

  lpclk_ctrl u0 (
    .clk_hf(clk_hf), .clk_fll(clk_fll), .clk32_xtal(clk32_xtal), .clk32_ext(clk32_ext),
    .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .fll_lock(fll_lock), .rtc_busy(rtc_busy), .fll_en(fll_en), .fll_ref(fll_ref),
    .rtc_clk(rtc_clk), .core_clk(core_clk));

  // R7: every core clock phase must last at least half the fastest period
  always @(core_clk) begin
    if (mon_on && ($realtime - last_t) < (FLL_HALF - 0.1)) runts++;
    last_t = $realtime;
  end
  always @(posedge rtc_clk) rtc_edges++;
  always @(posedge fll_ref) ref_edges++;

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk_hf); wr_en = 1'b1; wr_data = d;
    @(negedge clk_hf); wr_en = 1'b0;
    repeat (2) @(negedge clk_hf);
  endtask

  task automatic meas_core(output int p);
    longint t0;
    @(posedge core_clk); t0 = $time;
    repeat (4) @(posedge core_clk);
    p = int'(($time - t0) / 4);
  endtask

  task automatic meas_rtc(output int p);
    longint t0;
    @(posedge rtc_clk); t0 = $time;
    repeat (4) @(posedge rtc_clk);
    p = int'(($time - t0) / 4);
  endtask

  function automatic string vec_req(input int i);
    if (i == 8) return "R4";
    if (i == 9) return "R5";
    if (i >= 4 && i <= 7) return "R3";
    return "R2";
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    total++; bad++;
    $display("FAIL watchdog R7 act=timeout exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int p, e0, e1;
    rst_n = 0; wr_en = 0; wr_data = 0; fll_lock = 0; rtc_busy = 0;
    #(CLK_PERIOD * 5);
    rst_n = 1;
    #(CLK_PERIOD * 20);
    mon_on = 1;

    // R1 reset state
    check("R1 rd_data", int'(rd_data), 0);
    meas_core(p); check("R1 core period", p, CLK_PERIOD);
    meas_rtc(p);  check("R1 rtc period", p, 2*XT_HALF);

    // table walk: R2 ratios, R3 FLL with lock, R4 low-power, R5 bypass
    for (int i = 0; i < NVEC; i++) begin
      fll_lock = VEC[i][16];
      wr(VEC[i][31:24]);
      #(SETTLE);
      meas_core(p);
      check(vec_req(i), p, int'(VEC[i][15:0]));
    end

    // R6: 32k output during FLL operation
    fll_lock = 1; wr(8'h48); #(SETTLE);
    meas_rtc(p); check("R6 rtc while FLL", p, 2*XT_HALF);
    wr(8'h00); fll_lock = 0; #(SETTLE);

    // R9: refused while RTC busy
    rtc_busy = 1; wr(8'h04);
    check("R9 busy refuse rd", int'(rd_data), 0);
    meas_rtc(p); check("R9 busy rtc period", p, 2*XT_HALF);

    // R9: accepted when free, 32k stops
    rtc_busy = 0; wr(8'h04);
    check("R9 accept rd", int'(rd_data), 8'h04);
    e0 = rtc_edges; e1 = ref_edges;
    #1500;
    check("R9 rtc stopped", rtc_edges - e0, 0);
    check("R9 ref stopped", ref_edges - e1, 0);

    // R10: low-power request while off is dropped
    wr(8'h14);
    check("R10 lp refused rd", int'(rd_data), 8'h04);
    #(SETTLE);
    meas_core(p); check("R10 core stays hf", p, CLK_PERIOD);

    // R9: clearing turns the 32k clock back on
    wr(8'h00); #(SETTLE);
    meas_rtc(p); check("R9 rtc restarts", p, 2*XT_HALF);

    // R9: refused while low-power mode is active
    wr(8'h10); #(SETTLE);
    wr(8'h14);
    check("R9 lp blocks off rd", int'(rd_data), 8'h10);
    wr(8'h00); #(SETTLE);

    // R10: one write asking for both off and low-power
    wr(8'h14);
    check("R10 same-write rd", int'(rd_data), 8'h04);
    #(SETTLE);
    meas_core(p); check("R10 same-write core", p, CLK_PERIOD);
    wr(8'h00); #(SETTLE);

    // R11: unimplemented bit
    wr(8'h80);
    check("R11 bit7 rd", int'(rd_data), 0);

    // R8 ratio switch back-to-back, then R7 runt count over the whole run
    wr(8'h03); #200; wr(8'h01); #(SETTLE);
    meas_core(p); check("R8 ratio after quick change", p, 2*CLK_PERIOD);
    check("R7 runt phases", runts, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule